// File: doc/BRIEF.md
# Signed and Sign-Magnitude Comparator

This block compares two N-bit words X and Y and reports whether X is greater or less than Y. A single format input selects how the words are read: as sign-magnitude values or as two's complement values. The most significant bit of each word is taken apart as the sign. An unsigned comparator works on the remaining bits and produces a raw greater/less pair. A small correction stage then uses the two signs and the format to turn that raw pair into the final result. Equality is reported by neither output being set.

In sign-magnitude format the same path also orders floating-point words whose bits below the sign hold the exponent above the mantissa. NaN and infinity are not treated specially. The block is purely combinational: the outputs follow the inputs within the same cycle.

Top module: `sm_compare`

## Requirements
- R1: When both sign bits are 0, in either format, isGreater is 1 exactly when the lower WIDTH-1 bits of X exceed those of Y as unsigned numbers, and isLess is 1 exactly when they are below.
- R2: In sign-magnitude format (fmtTwos=0), a word with sign 0 compared against a word with sign 1 gives isGreater=1 and isLess=0 whatever the lower bits are, so positive zero (0x00 at width 8) is greater than negative zero (0x80).
- R3: In sign-magnitude format, X with sign 1 against Y with sign 0 gives isLess=1 and isGreater=0.
- R4: In sign-magnitude format with both signs 1, the unsigned result on the lower bits is reversed: isGreater is 1 when X's lower bits are below Y's, and isLess is 1 when they are above.
- R5: In two's complement format (fmtTwos=1), an MSB of 0 against an MSB of 1 gives isGreater=1, and an MSB of 1 against an MSB of 0 gives isLess=1.
- R6: In two's complement format with both MSBs 1, the result equals the unsigned comparison of the lower bits, not reversed.
- R7: isGreater and isLess are never both 1, and both are 0 whenever X and Y are the same bit pattern.
- R8: In sign-magnitude format a floating-point word laid out as sign, exponent (upper bits), mantissa (lower bits) is ordered correctly: a larger exponent wins for positive words and loses for negative words, the mantissa deciding only when the exponents match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opX | input | WIDTH | First operand X; bit WIDTH-1 is its sign |
| opY | input | WIDTH | Second operand Y; bit WIDTH-1 is its sign |
| fmtTwos | input | 1 | 0 reads both words as sign-magnitude, 1 as two's complement |
| isGreater | output | 1 | 1 when X is greater than Y in the chosen format |
| isLess | output | 1 | 1 when X is less than Y in the chosen format |

## Verification
Both results are combinational, so each is due in the same cycle its operands are applied, with no register on the way. The bench therefore drives operands and format on the falling clock edge and samples isGreater and isLess a quarter period later, well before the next rising edge, so each check sees only the stimulus just applied. The directed table covers every sign pairing in both formats plus the zero and floating-point cases, and a second width-5 instance is swept over all operand pairs in both formats against integer ordering.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  typedef enum logic {
    FMT_SIGN_MAG = 1'b0,
    FMT_TWOS     = 1'b1
  } fmt_e;

  // Strobes from the sign control to the result datapath.
  typedef struct packed {
    logic forceGt;    // signs differ, X is the non-negative one
    logic forceLt;    // signs differ, X is the negative one
    logic swapSense;  // both negative in sign-magnitude: reverse raw result
  } fix_strobe_t;

  localparam int MAG_ARCH_RIPPLE = 0;
  localparam int MAG_ARCH_TREE   = 1;

endpackage

// File: rtl/cmp_mag_unit.sv
module cmp_mag_unit
  import cmp_pkg::*;
#(
  parameter int MAG_W    = 7,
  parameter int MAG_ARCH = MAG_ARCH_TREE
) (
  input  logic [MAG_W-1:0] magX,
  input  logic [MAG_W-1:0] magY,
  output logic             magGt,
  output logic             magLt
);

  generate
    if (MAG_ARCH == MAG_ARCH_RIPPLE) begin : g_ripple
      // Chain from the MSB down; the first differing bit decides.
      logic [MAG_W:0] gChain;
      logic [MAG_W:0] lChain;
      assign gChain[MAG_W] = 1'b0;
      assign lChain[MAG_W] = 1'b0;
      for (genvar i = MAG_W - 1; i >= 0; i--) begin : g_bit
        assign gChain[i] = gChain[i+1] | (~lChain[i+1] & magX[i] & ~magY[i]);
        assign lChain[i] = lChain[i+1] | (~gChain[i+1] & ~magX[i] & magY[i]);
      end
      assign magGt = gChain[0];
      assign magLt = lChain[0];
    end else begin : g_tree
      localparam int LEVELS = (MAG_W > 1) ? $clog2(MAG_W) : 0;
      localparam int PAD_W  = 1 << LEVELS;
      logic [LEVELS:0][PAD_W-1:0] gLvl;
      logic [LEVELS:0][PAD_W-1:0] lLvl;

      for (genvar i = 0; i < PAD_W; i++) begin : g_leaf
        if (i < MAG_W) begin : g_real
          assign gLvl[0][i] = magX[i] & ~magY[i];
          assign lLvl[0][i] = ~magX[i] & magY[i];
        end else begin : g_pad
          assign gLvl[0][i] = 1'b0;
          assign lLvl[0][i] = 1'b0;
        end
      end

      for (genvar k = 0; k < LEVELS; k++) begin : g_level
        for (genvar j = 0; j < PAD_W; j++) begin : g_node
          if (j < (PAD_W >> (k + 1))) begin : g_merge
            // upper half (2j+1) dominates unless it reports equal
            assign gLvl[k+1][j] = gLvl[k][2*j+1] | (~lLvl[k][2*j+1] & gLvl[k][2*j]);
            assign lLvl[k+1][j] = lLvl[k][2*j+1] | (~gLvl[k][2*j+1] & lLvl[k][2*j]);
          end else begin : g_idle
            assign gLvl[k+1][j] = 1'b0;
            assign lLvl[k+1][j] = 1'b0;
          end
        end
      end

      assign magGt = gLvl[LEVELS][0];
      assign magLt = lLvl[LEVELS][0];
    end
  endgenerate

endmodule

// File: rtl/cmp_sign_ctrl.sv
module cmp_sign_ctrl
  import cmp_pkg::*;
(
  input  logic        signX,
  input  logic        signY,
  input  fmt_e        fmt,
  output fix_strobe_t strobe
);

  always_comb begin
    strobe = '0;
    if (signX != signY) begin
      // Same rule in both formats: the non-negative word is larger.
      strobe.forceGt = ~signX;
      strobe.forceLt = signX;
    end else if (signX && (fmt == FMT_SIGN_MAG)) begin
      strobe.swapSense = 1'b1;
    end
  end

endmodule

// File: rtl/sm_cmp_datapath.sv
module sm_cmp_datapath
  import cmp_pkg::*;
#(
  parameter int MAG_W    = 7,
  parameter int MAG_ARCH = MAG_ARCH_TREE
) (
  input  logic [MAG_W-1:0] magX,
  input  logic [MAG_W-1:0] magY,
  input  fix_strobe_t      strobe,
  output logic             greater,
  output logic             less
);

  logic rawGt;
  logic rawLt;

  cmp_mag_unit #(
    .MAG_W   (MAG_W),
    .MAG_ARCH(MAG_ARCH)
  ) u_mag (
    .magX (magX),
    .magY (magY),
    .magGt(rawGt),
    .magLt(rawLt)
  );

  always_comb begin
    if (strobe.forceGt) begin
      greater = 1'b1;
      less    = 1'b0;
    end else if (strobe.forceLt) begin
      greater = 1'b0;
      less    = 1'b1;
    end else if (strobe.swapSense) begin
      greater = rawLt;
      less    = rawGt;
    end else begin
      greater = rawGt;
      less    = rawLt;
    end
  end

endmodule

// File: rtl/sm_compare.sv
module sm_compare
  import cmp_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int MAG_ARCH = MAG_ARCH_TREE
) (
  input  logic [WIDTH-1:0] opX,
  input  logic [WIDTH-1:0] opY,
  input  logic             fmtTwos,
  output logic             isGreater,
  output logic             isLess
);

  localparam int MAG_W = WIDTH - 1;

  fix_strobe_t strobe;
  fmt_e        fmtSel;

  assign fmtSel = fmt_e'(fmtTwos);

  cmp_sign_ctrl u_ctrl (
    .signX (opX[WIDTH-1]),
    .signY (opY[WIDTH-1]),
    .fmt   (fmtSel),
    .strobe(strobe)
  );

  sm_cmp_datapath #(
    .MAG_W   (MAG_W),
    .MAG_ARCH(MAG_ARCH)
  ) u_dp (
    .magX   (opX[MAG_W-1:0]),
    .magY   (opY[MAG_W-1:0]),
    .strobe (strobe),
    .greater(isGreater),
    .less   (isLess)
  );

endmodule

// File: rtl/sm_compare_chk.sv
module sm_compare_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] opX,
  input logic [WIDTH-1:0] opY,
  input logic             fmtTwos,
  input logic             isGreater,
  input logic             isLess
);

  logic             sx;
  logic             sy;
  logic [WIDTH-2:0] lowX;
  logic [WIDTH-2:0] lowY;

  assign sx   = opX[WIDTH-1];
  assign sy   = opY[WIDTH-1];
  assign lowX = opX[WIDTH-2:0];
  assign lowY = opY[WIDTH-2:0];

  always_comb begin
    assert_never_both_R7: assert (!(isGreater && isLess))
      else $error("R7: both outputs set");
    if (opX == opY) begin
      assert_equal_quiet_R7: assert (!isGreater && !isLess)
        else $error("R7: equal words not quiet");
    end
    if (!sx && sy) begin
      assert_pos_beats_neg_R2: assert (isGreater && !isLess)
        else $error("R2/R5: non-negative X not greater");
    end
    if (sx && !sy) begin
      assert_neg_loses_R3: assert (isLess && !isGreater)
        else $error("R3/R5: negative X not less");
    end
    if (sx && sy && !fmtTwos) begin
      assert_sm_reverse_R4: assert (isGreater == (lowX < lowY) && isLess == (lowX > lowY))
        else $error("R4: negative sign-magnitude not reversed");
    end
    if (sx == sy && (fmtTwos || !sx)) begin
      assert_direct_low_R6: assert (isGreater == (lowX > lowY) && isLess == (lowX < lowY))
        else $error("R1/R6: direct lower-bit order broken");
    end
  end

endmodule

bind sm_compare sm_compare_chk #(.WIDTH(WIDTH)) u_chk (
  .opX      (opX),
  .opY      (opY),
  .fmtTwos  (fmtTwos),
  .isGreater(isGreater),
  .isLess   (isLess)
);

// File: tb/test_sm_compare.sv
module test_sm_compare;

  localparam int CLK_PERIOD = 10;
  localparam int W         = 8;
  localparam int WS        = 5;
  localparam int NVEC      = 16;
  localparam int ENTRY_W   = 1 + W + W + 2 + 4;

  // entry: {req[3:0], fmt, x, y, expGreater, expLess}
  localparam logic [ENTRY_W-1:0] VECS [NVEC] = '{
    {4'd1, 1'b0, 8'h05, 8'h03, 1'b1, 1'b0},  // R1
    {4'd1, 1'b0, 8'h03, 8'h05, 1'b0, 1'b1},  // R1
    {4'd2, 1'b0, 8'h05, 8'h85, 1'b1, 1'b0},  // R2
    {4'd2, 1'b0, 8'h00, 8'h80, 1'b1, 1'b0},  // R2 +0 vs -0
    {4'd3, 1'b0, 8'h80, 8'h00, 1'b0, 1'b1},  // R3
    {4'd3, 1'b0, 8'hFF, 8'h7F, 1'b0, 1'b1},  // R3
    {4'd4, 1'b0, 8'h85, 8'h83, 1'b0, 1'b1},  // R4
    {4'd4, 1'b0, 8'h83, 8'h85, 1'b1, 1'b0},  // R4
    {4'd6, 1'b1, 8'h85, 8'h83, 1'b1, 1'b0},  // R6
    {4'd6, 1'b1, 8'hFF, 8'h80, 1'b1, 1'b0},  // R6
    {4'd5, 1'b1, 8'h7F, 8'h80, 1'b1, 1'b0},  // R5
    {4'd5, 1'b1, 8'h80, 8'h00, 1'b0, 1'b1},  // R5
    {4'd7, 1'b1, 8'h42, 8'h42, 1'b0, 1'b0},  // R7
    {4'd7, 1'b0, 8'hC1, 8'hC1, 1'b0, 1'b0},  // R7
    {4'd8, 1'b0, 8'h38, 8'h2F, 1'b1, 1'b0},  // R8 exponent decides
    {4'd8, 1'b0, 8'hB0, 8'hAF, 1'b0, 1'b1}   // R8 negative, reversed
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  logic [W-1:0]  opX = '0;
  logic [W-1:0]  opY = '0;
  logic          fmtTwos = 1'b0;
  logic          isGreater;
  logic          isLess;

  logic [WS-1:0] sX = '0;
  logic [WS-1:0] sY = '0;
  logic          sFmt = 1'b0;
  logic          sGreater;
  logic          sLess;

  always #(CLK_PERIOD/2) clk = ~clk;

  sm_compare #(.WIDTH(W), .MAG_ARCH(1)) i_sm_compare (
    .opX(opX), .opY(opY), .fmtTwos(fmtTwos),
    .isGreater(isGreater), .isLess(isLess)
  );

  sm_compare #(.WIDTH(WS), .MAG_ARCH(0)) i_sm_compare_w5 (
    .opX(sX), .opY(sY), .fmtTwos(sFmt),
    .isGreater(sGreater), .isLess(sLess)
  );

  function automatic string reqName(input int r);
    case (r)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic g, input logic l,
                       input logic eg, input logic el);
    checks++;
    if (g !== eg || l !== el) begin
      failures++;
      $display("FAIL %s: got gt=%0b lt=%0b expected gt=%0b lt=%0b", req, g, l, eg, el);
    end
  endtask

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // reset state: zero operands read as equal (R7)
    @(negedge clk);
    #(CLK_PERIOD/4);
    check("R7 reset", isGreater, isLess, 1'b0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      fmtTwos = VECS[i][2*W+2];
      opX     = VECS[i][2*W+1:W+2];
      opY     = VECS[i][W+1:2];
      #(CLK_PERIOD/4);
      check(reqName(int'(VECS[i][ENTRY_W-1:ENTRY_W-4])), isGreater, isLess,
            VECS[i][1], VECS[i][0]);
    end

    // exhaustive sweep at width 5 against integer ordering
    for (int f = 0; f < 2; f++) begin
      for (int a = 0; a < (1 << WS); a++) begin
        for (int b = 0; b < (1 << WS); b++) begin
          int  va;
          int  vb;
          logic eg;
          logic el;
          string tag;
          @(negedge clk);
          sFmt = f[0];
          sX   = a[WS-1:0];
          sY   = b[WS-1:0];
          if (f == 1) begin
            va = (a >= (1 << (WS-1))) ? a - (1 << WS) : a;
            vb = (b >= (1 << (WS-1))) ? b - (1 << WS) : b;
          end else begin
            va = (a >= (1 << (WS-1))) ? -(a - (1 << (WS-1))) : a;
            vb = (b >= (1 << (WS-1))) ? -(b - (1 << (WS-1))) : b;
          end
          if (sX[WS-1] != sY[WS-1]) begin
            eg  = ~sX[WS-1];
            el  = sX[WS-1];
            tag = (f == 1) ? "R5 sweep" : (sX[WS-1] ? "R3 sweep" : "R2 sweep");
          end else begin
            eg  = (va > vb);
            el  = (va < vb);
            tag = (a == b) ? "R7 sweep" : (!sX[WS-1] ? "R1 sweep" :
                  (f == 1 ? "R6 sweep" : "R4 sweep"));
          end
          #(CLK_PERIOD/4);
          check(tag, sGreater, sLess, eg, el);
          if (sGreater && sLess) check("R7 both", sGreater, sLess, 1'b0, 1'b0);
        end
      end
    end

    done = 1'b1;
    finishRun();
  end

endmodule